// File: doc/BRIEF.md
# CCD Frame Sequencing Controller with Row-of-Interest Dump

This controller steps a full-frame image sensor through one complete exposure and readout. A frame request starts an integration window. During that window the mechanical shutter is open and, when the pinned low-dark-current mode is selected, every sensor clock is held low. The shutter then closes, and one serial clear-out line empties the horizontal register. After that the controller walks every sensor row in order, from row 0 up to the last row.

Rows inside an inclusive window of interest are shifted into the serial register and then read out as a full line. A row outside the window is discarded by a vertical shift alone. During that shift a lateral-drain enable holds the horizontal phases high, so the charge spills into the drain. The serial register cannot be fully emptied this way. For that reason, a flush line with its data marked invalid runs before any kept row follows dumped rows. With vertical binning enabled, rows are handled in pairs: each pair gets two vertical shifts before one line read.

The vertical and horizontal clock sequencers are separate blocks. The controller drives them through single-cycle start pulses and waits for their done pulses. Frame settings are captured when the frame starts. A one-cycle frame-done pulse closes the sequence.

Top module: `ccd_frame_ctrl`

## Requirements
- R1: Out of reset the shutter-close output is high, and both start outputs, the drain enable, the clock hold output and frame done are low.
- R2: A frame start seen while idle opens the shutter (shutter_close_o low) for exactly int_len_i+1 cycles. A frame start seen while a frame is running has no effect.
- R3: The shutter closes one cycle before the serial clear-out line starts. The clear-out is the first handshake of the frame and is a horizontal start with hread_valid_o low. The shutter stays closed during every shift and read.
- R4: Each frame issues exactly ROWS vertical shifts, for rows 0 to ROWS-1 in order. Each kept line is followed by exactly one horizontal start with hread_valid_o high, and each handshake waits for its done pulse.
- R5: A row r is kept when first <= r <= last. Any other row is dumped: its vertical shift has drain_en_o high and no line read follows it. If first > last, every row is dumped.
- R6: After one or more dumped rows, and before the vertical shift of the next kept line, exactly one flush line runs (a horizontal start with hread_valid_o low). Kept lines that follow kept lines, or follow the clear-out, get no flush.
- R7: When the pinned mode is selected, hold_low_o is high during every integration cycle. It is low in all other cycles, and low throughout a frame run in normal mode.
- R8: With binning on, rows pair up as (2k, 2k+1). A pair gets two vertical shifts and then one read. The pair is kept if either of its rows is in the window. If ROWS is odd, the last row forms a group on its own.
- R9: frame_done_o pulses high for one cycle after the final handshake of a frame. Row window, mode and binning are taken from the inputs in the cycle the frame starts.
- R10: Each start output is high for a single cycle, and the two start outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Request one frame |
| int_len_i | input | INT_W | Integration length; the shutter is open int_len_i+1 cycles |
| roi_first_i | input | ROW_W | First kept row, inclusive |
| roi_last_i | input | ROW_W | Last kept row, inclusive |
| mpp_i | input | 1 | Pinned mode: hold all clocks low while integrating |
| vbin2_i | input | 1 | Vertical binning by two |
| vshift_start_o | output | 1 | Start one vertical row shift |
| vshift_done_i | input | 1 | Vertical shift finished |
| hread_start_o | output | 1 | Start one horizontal line sequence |
| hread_valid_o | output | 1 | The started line carries image data (low for clear/flush) |
| hread_done_i | input | 1 | Horizontal line finished |
| drain_en_o | output | 1 | Lateral drain on, horizontal phases held high |
| shutter_close_o | output | 1 | Shutter closed |
| hold_low_o | output | 1 | All sensor clocks held low |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench runs five frames covering these settings:
- a full window;
- a narrow window in the middle, in pinned mode;
- a binned window that starts on an odd row;
- an empty window;
- a binned window holding only the last row, with a second start request and new window inputs applied mid-frame.

A design that skipped the flush after dumps, or flushed between two kept lines, would show a missing or extra invalid read in the handshake stream. A design that decided a binned pair by its first row only would dump pair 10/11 for a window that starts at 11. A design that re-read the window inputs or restarted on the second request would issue extra or wrong handshakes after the intended frame. Off-by-one faults in the integration count or the shutter timing show up as a wrong open-cycle count, or as a clear-out that does not follow the shutter closing by exactly one cycle.

// File: rtl/ccd_frame_pkg.sv
package ccd_frame_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_INTEG, S_SHUT, S_CLR, S_CLR_W, S_NEXT, S_FLUSH, S_FLUSH_W,
    S_VSH, S_VSH_W, S_READ, S_READ_W, S_DONE
  } frame_state_t;
endpackage

// File: rtl/ccd_integ_timer.sv
module ccd_integ_timer #(
  parameter int INT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [INT_W-1:0] len_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [INT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= len_i;
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ccd_row_ctr.sv
module ccd_row_ctr #(
  parameter int ROWS  = 330,
  parameter int ROW_W = $clog2(ROWS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o,
  output logic             end_o
);
  localparam logic [ROW_W-1:0] LastIdx = ROW_W'(ROWS);

  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            row_q <= '0;
    else if (clr_i)                         row_q <= '0;
    else if (step_i && row_q != LastIdx)    row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;
  assign end_o = (row_q == LastIdx);
endmodule

// File: rtl/ccd_roi_filter.sv
module ccd_roi_filter #(
  parameter int ROWS  = 330,
  parameter int ROW_W = $clog2(ROWS + 1)
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] first_i,
  input  logic [ROW_W-1:0] last_i,
  input  logic             bin2_i,
  output logic             pair_o,
  output logic             keep_o
);
  localparam int EXT_W = ROW_W + 1;

  logic [EXT_W-1:0] row_a, row_b, lo, hi;
  logic             range_ok, in_a, in_b;

  always_comb begin
    row_a    = {1'b0, row_i};
    row_b    = row_a + 1'b1;
    lo       = {1'b0, first_i};
    hi       = {1'b0, last_i};
    range_ok = (lo <= hi);
    in_a     = range_ok && row_a >= lo && row_a <= hi;
    in_b     = range_ok && row_b >= lo && row_b <= hi;
    pair_o   = bin2_i && (row_b < EXT_W'(ROWS));
    keep_o   = in_a || (pair_o && in_b);
  end
endmodule

// File: rtl/ccd_frame_ctrl.sv
module ccd_frame_ctrl
  import ccd_frame_pkg::*;
#(
  parameter int ROWS  = 330,
  parameter int INT_W = 16,
  parameter int ROW_W = $clog2(ROWS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic [INT_W-1:0] int_len_i,
  input  logic [ROW_W-1:0] roi_first_i,
  input  logic [ROW_W-1:0] roi_last_i,
  input  logic             mpp_i,
  input  logic             vbin2_i,
  output logic             vshift_start_o,
  input  logic             vshift_done_i,
  output logic             hread_start_o,
  output logic             hread_valid_o,
  input  logic             hread_done_i,
  output logic             drain_en_o,
  output logic             shutter_close_o,
  output logic             hold_low_o,
  output logic             frame_done_o
);
  frame_state_t     state_q, state_d;
  logic [ROW_W-1:0] first_q, last_q;
  logic             mpp_q, bin_q;
  logic             keep_q, dump_q, dirty_q, grp_left_q;
  logic             idle_go, int_exp, row_end, row_step, pair_w, keep_w;
  logic [ROW_W-1:0] row_w;

  assign idle_go  = (state_q == S_IDLE) && frame_start_i;
  assign row_step = (state_q == S_VSH_W) && vshift_done_i;

  ccd_integ_timer #(.INT_W(INT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (idle_go),
    .len_i    (int_len_i),
    .run_i    (state_q == S_INTEG),
    .expired_o(int_exp)
  );

  ccd_row_ctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (idle_go),
    .step_i(row_step),
    .row_o (row_w),
    .end_o (row_end)
  );

  ccd_roi_filter #(.ROWS(ROWS), .ROW_W(ROW_W)) u_roi (
    .row_i  (row_w),
    .first_i(first_q),
    .last_i (last_q),
    .bin2_i (bin_q),
    .pair_o (pair_w),
    .keep_o (keep_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (frame_start_i) state_d = S_INTEG;
      S_INTEG:   if (int_exp) state_d = S_SHUT;
      S_SHUT:    state_d = S_CLR;
      S_CLR:     state_d = S_CLR_W;
      S_CLR_W:   if (hread_done_i) state_d = S_NEXT;
      S_NEXT: begin
        if (row_end)                 state_d = S_DONE;
        else if (keep_w && dirty_q)  state_d = S_FLUSH;
        else                         state_d = S_VSH;
      end
      S_FLUSH:   state_d = S_FLUSH_W;
      S_FLUSH_W: if (hread_done_i) state_d = S_VSH;
      S_VSH:     state_d = S_VSH_W;
      S_VSH_W: begin
        if (vshift_done_i) begin
          if (grp_left_q)  state_d = S_VSH;
          else if (keep_q) state_d = S_READ;
          else             state_d = S_NEXT;
        end
      end
      S_READ:    state_d = S_READ_W;
      S_READ_W:  if (hread_done_i) state_d = S_NEXT;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      first_q    <= '0;
      last_q     <= '0;
      mpp_q      <= 1'b0;
      bin_q      <= 1'b0;
      keep_q     <= 1'b0;
      dump_q     <= 1'b0;
      dirty_q    <= 1'b0;
      grp_left_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idle_go) begin
        first_q <= roi_first_i;
        last_q  <= roi_last_i;
        mpp_q   <= mpp_i;
        bin_q   <= vbin2_i;
      end
      if (state_q == S_CLR_W && hread_done_i)   dirty_q <= 1'b0;
      if (state_q == S_FLUSH_W && hread_done_i) dirty_q <= 1'b0;
      if (state_q == S_NEXT && !row_end) begin
        keep_q     <= keep_w;
        dump_q     <= !keep_w;
        grp_left_q <= pair_w;
        if (!keep_w) dirty_q <= 1'b1;
      end
      if (row_step && grp_left_q) grp_left_q <= 1'b0;
    end
  end

  assign vshift_start_o  = (state_q == S_VSH);
  assign hread_start_o   = (state_q == S_CLR) || (state_q == S_FLUSH) || (state_q == S_READ);
  assign hread_valid_o   = (state_q == S_READ);
  assign drain_en_o      = dump_q && ((state_q == S_VSH) || (state_q == S_VSH_W));
  assign shutter_close_o = (state_q != S_INTEG);
  assign hold_low_o      = mpp_q && (state_q == S_INTEG);
  assign frame_done_o    = (state_q == S_DONE);
endmodule

// File: rtl/ccd_frame_ctrl_chk.sv
module ccd_frame_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic vshift_start_o,
  input logic hread_start_o,
  input logic drain_en_o,
  input logic shutter_close_o,
  input logic hold_low_o,
  input logic frame_done_o
);
  // R10
  vstart_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vshift_start_o |=> !vshift_start_o);
  // R10
  hstart_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hread_start_o |=> !hread_start_o);
  // R10
  start_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vshift_start_o && hread_start_o));
  // R5
  drain_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_en_o |-> !hread_start_o);
  // R3
  dark_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hread_start_o || vshift_start_o) |-> shutter_close_o);
  // R7
  hold_in_integ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_low_o |-> !shutter_close_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
endmodule

bind ccd_frame_ctrl ccd_frame_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .vshift_start_o (vshift_start_o),
  .hread_start_o  (hread_start_o),
  .drain_en_o     (drain_en_o),
  .shutter_close_o(shutter_close_o),
  .hold_low_o     (hold_low_o),
  .frame_done_o   (frame_done_o)
);

// File: tb/tb_ccd_frame_ctrl.sv
module tb_ccd_frame_ctrl;
  localparam int ROWS  = 330;
  localparam int INT_W = 16;
  localparam int ROW_W = $clog2(ROWS + 1);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             frame_start_i = 1'b0;
  logic [INT_W-1:0] int_len_i = '0;
  logic [ROW_W-1:0] roi_first_i = '0, roi_last_i = '0;
  logic             mpp_i = 1'b0, vbin2_i = 1'b0;
  logic             vshift_start_o, vshift_done_i, hread_start_o, hread_valid_o;
  logic             hread_done_i, drain_en_o, shutter_close_o, hold_low_o, frame_done_o;

  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  int open_cnt = 0, hold_cnt = 0, done_cnt = 0;
  int vcnt = 0, hcnt = 0, vlat = 1, hlat = 3;
  bit sh1 = 1'b1, sh2 = 1'b1, first_ev = 1'b0;

  always #5 clk_i = ~clk_i;

  ccd_frame_ctrl #(.ROWS(ROWS), .INT_W(INT_W)) dut (.*);

  initial begin
    vshift_done_i = 1'b0;
    hread_done_i  = 1'b0;
  end

  // sequencer models
  always @(negedge clk_i) begin
    vshift_done_i <= (vcnt == 1);
    hread_done_i  <= (hcnt == 1);
    if (vcnt > 0) vcnt = vcnt - 1;
    if (hcnt > 0) hcnt = hcnt - 1;
    if (vshift_start_o) vcnt = vlat;
    if (hread_start_o)  hcnt = hlat;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected handshakes
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!shutter_close_o) open_cnt++;
      if (hold_low_o) hold_cnt++;
      if (frame_done_o) done_cnt++;
      if (vshift_start_o || hread_start_o) begin
        int code;
        code = vshift_start_o ? (drain_en_o ? 3 : 2) : (hread_valid_o ? 1 : 0);
        if (first_ev) begin
          chk(sh1 && !sh2 && code == 0, "R3 clear-out after shutter close",
              {sh2, sh1, code[1:0]}, 3'b010 << 1);
          first_ev = 1'b0;
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 no handshake expected", code, -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(code == e, t, code, e);
        end
      end
      sh2 = sh1;
      sh1 = shutter_close_o;
    end
  end

  function automatic bit in_win(int r, int f, int l);
    return (f <= l) && (r >= f) && (r <= l);
  endfunction

  // driver: builds the expected handshake stream
  task automatic build_expect(int f, int l, bit bin);
    bit dirty = 1'b0;
    int r = 0;
    exp_q.push_back(0); tag_q.push_back("R3 clear-out");
    while (r < ROWS) begin
      int g;
      bit keep;
      g = (bin && r + 1 < ROWS) ? 2 : 1;
      keep = in_win(r, f, l) || (g == 2 && in_win(r + 1, f, l));
      if (keep) begin
        if (dirty) begin exp_q.push_back(0); tag_q.push_back("R6 flush"); end
        dirty = 1'b0;
        for (int k = 0; k < g; k++) begin
          exp_q.push_back(2); tag_q.push_back(g == 2 ? "R8 binned keep shift" : "R4 keep shift");
        end
        exp_q.push_back(1); tag_q.push_back("R4 line read");
      end else begin
        for (int k = 0; k < g; k++) begin
          exp_q.push_back(3); tag_q.push_back("R5 dump shift");
        end
        dirty = 1'b1;
      end
      r += g;
    end
  endtask

  task automatic run_frame(int il, int f, int l, bit mpp, bit bin, bit disturb);
    open_cnt = 0; hold_cnt = 0; done_cnt = 0;
    build_expect(f, l, bin);
    @(negedge clk_i);
    int_len_i = INT_W'(il); roi_first_i = ROW_W'(f); roi_last_i = ROW_W'(l);
    mpp_i = mpp; vbin2_i = bin; frame_start_i = 1'b1; first_ev = 1'b1;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    if (disturb) begin
      repeat (40) @(negedge clk_i);
      roi_first_i = '0; roi_last_i = ROW_W'(ROWS - 1); vbin2_i = 1'b0; mpp_i = ~mpp;
      frame_start_i = 1'b1;
      @(negedge clk_i);
      frame_start_i = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk_i);
    repeat (30) @(negedge clk_i);
    chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
    chk(exp_q.size() == 0, "R4 all handshakes seen", exp_q.size(), 0);
    chk(open_cnt == il + 1, "R2 shutter open cycles", open_cnt, il + 1);
    chk(hold_cnt == (mpp ? il + 1 : 0), "R7 hold cycles", hold_cnt, mpp ? il + 1 : 0);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(shutter_close_o == 1'b1, "R1 shutter closed", shutter_close_o, 1);
    chk(!vshift_start_o && !hread_start_o, "R1 no starts", {vshift_start_o, hread_start_o}, 0);
    chk(!drain_en_o && !hold_low_o && !frame_done_o, "R1 quiet",
        {drain_en_o, hold_low_o, frame_done_o}, 0);
    run_frame(5, 0, ROWS - 1, 1'b0, 1'b0, 1'b0);   // R4 full window
    vlat = 2; hlat = 1;
    run_frame(0, 10, 20, 1'b1, 1'b0, 1'b0);        // R5 R6 R7
    run_frame(3, 11, 14, 1'b0, 1'b1, 1'b0);        // R8 odd first row
    run_frame(2, 50, 40, 1'b1, 1'b0, 1'b0);        // R5 empty window
    vlat = 3; hlat = 2;
    run_frame(7, ROWS - 1, ROWS - 1, 1'b0, 1'b1, 1'b1); // R2 R9 latched, restart ignored
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL R9 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule